// File: doc/BRIEF.md
# Pseudo-SRAM Page Burst Reader

This block drives the read side of an asynchronous pseudo-SRAM and fetches a short run of consecutive 16-bit words, all lying inside one aligned page of eight words. A requester presents a start address and a word count. Once the request is taken, the engine pulls chip enable and output enable low and keeps them low for the whole run. It leaves the address bits above the page field untouched and steps only the three in-page bits. The first word is given the full random-access time. Each later word in the page is given only the shorter page cycle. Each word comes back on a streaming output as a single-cycle valid pulse, and the final word carries a last marker.

Every analog timing figure is a parameter in picoseconds. The block divides each one by the clock period and rounds the result up to a whole number of cycles. With the default 4 ns clock this gives 19 cycles for the first access, 8 cycles for each page step and 5 cycles of bus float after a run. A request that would run past the end of its page, or that asks for zero words, is refused with an error pulse and causes no bus activity. Elaboration-time checks refuse any parameter set in which a full eight-word run would exceed the longest page-mode period the memory allows.

Top module: `psram_page_reader`

## Requirements
- R1: After reset, mem_ce_n and mem_oe_n are 1, rd_valid and req_err are 0, and req_ready is 1.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. Its length must be 1 to 8 and its in-page offset (req_addr[2:0]) plus its length must not exceed 8. Otherwise req_err is 1 for exactly the next cycle, the bus stays disabled and req_ready stays 1.
- R3: For the whole of a run, mem_ce_n and mem_oe_n are both 0, and mem_addr[21:3] keeps the value of req_addr[21:3].
- R4: The first word is sampled from mem_dq on the edge ACC_CYC = ceil(T_ACC_PS/CLK_PS) cycles after the accepting edge (19 by default), and rd_valid is 1 in the cycle after that edge.
- R5: On each sampling edge that is not the last, mem_addr[2:0] advances by one. The next word is sampled PAGE_CYC = ceil(T_PAGE_PS/CLK_PS) cycles later (8 by default).
- R6: rd_valid pulses exactly once per requested word, each pulse lasting one cycle. rd_data holds the memory word at the address being driven at the sampling edge, and rd_last is 1 only with the final word.
- R7: ACC_CYC + 7*PAGE_CYC must not exceed the page-mode limit in cycles; this is checked at elaboration. While enabled, no run lasts that many cycles.
- R8: After the last sample, mem_ce_n and mem_oe_n return to 1. req_ready then stays 0 for FLOAT_CYC = ceil(T_FLOAT_PS/CLK_PS) cycles (5 by default), so the bus has floated before the next run starts.
- R9: A request presented while req_ready is 0 is ignored: req_err stays 0 and the run in progress continues unchanged.
- R10: A run that ends exactly on the page boundary is accepted. This covers offset 0 with length 8 and offset 7 with length 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 22 | Word address of the first word |
| req_len | input | 4 | Number of words, 1 to 8 |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_err | output | 1 | One-cycle pulse for a refused request |
| rd_valid | output | 1 | One-cycle pulse per returned word |
| rd_data | output | 16 | Returned word |
| rd_last | output | 1 | Marks the final word of a run |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 22 | Memory word address |
| mem_dq | input | 16 | Memory read data |

## Verification
The hardest situation to reach from the ports is a sample taken one cycle early. If the data bus is tied straight to a function of the address, an early sample still returns correct-looking data. The bench therefore models the memory. It drives a garbage word until the full access time has passed since chip enable fell, or the page time since the last address change, and only then drives the true contents. Random offsets and lengths, including refused and boundary cases, are mixed with requests injected in the middle of a run to exercise the ignore path.

// File: rtl/psram_pg_pkg.sv
package psram_pg_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_READ    = 2'd1,
      ST_RECOVER = 2'd2
   } pg_state_e;

   // ceiling division used to turn picosecond figures into clock counts
   function automatic int cdiv(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int imax3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/psram_pg_reqchk.sv
module psram_pg_reqchk #(
   parameter int PAGE_BITS = 3,
   parameter int LEN_W     = PAGE_BITS + 1
) (
   input  logic [PAGE_BITS-1:0] offset,
   input  logic [LEN_W-1:0]     len,
   output logic                 fits
);
   localparam int PAGE_WORDS = 1 << PAGE_BITS;
   localparam int SUM_W      = LEN_W + 1;

   logic [SUM_W-1:0] span;

   always_comb begin
      span = {{(SUM_W-PAGE_BITS){1'b0}}, offset} + {1'b0, len};
      fits = (len != '0) && (span <= SUM_W'(PAGE_WORDS));
   end

   initial begin
      if (LEN_W < PAGE_BITS + 1)
         $fatal(1, "length field too narrow for a full page");
   end
endmodule

// File: rtl/psram_pg_timer.sv
module psram_pg_timer #(
   parameter int MAX_CYC = 19,
   localparam int TW     = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          done
);
   generate
      if (MAX_CYC == 1) begin : g_single
         // every interval is a single cycle: nothing to count
         assign done = 1'b1;
      end else begin : g_count
         logic [TW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (load)
               cnt_q <= load_val;
            else if (cnt_q != '0)
               cnt_q <= cnt_q - 1'b1;
         end
         assign done = (cnt_q == '0);
      end
   endgenerate

   initial begin
      if (MAX_CYC < 1) $fatal(1, "timer needs at least one cycle");
   end
endmodule

// File: rtl/psram_pg_capture.sv
module psram_pg_capture #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe,
   input  logic              last_in,
   input  logic [DATA_W-1:0] dq,
   output logic              valid,
   output logic [DATA_W-1:0] data,
   output logic              last
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         data  <= '0;
         last  <= 1'b0;
      end else begin
         valid <= strobe;
         last  <= strobe & last_in;
         if (strobe) data <= dq;
      end
   end

   // R6: a valid pulse never lasts more than one cycle
   p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid || $past(strobe));
   // R6: last only accompanies a valid word
   p_last_with_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      last |-> valid);
endmodule

// File: rtl/psram_page_reader.sv
module psram_page_reader
   import psram_pg_pkg::*;
#(
   parameter int ADDR_W      = 22,
   parameter int DATA_W      = 16,
   parameter int PAGE_BITS   = 3,
   parameter int CLK_PS      = 4000,
   parameter int T_ACC_PS    = 75000,
   parameter int T_PAGE_PS   = 30000,
   parameter int T_FLOAT_PS  = 20000,
   parameter int T_PM_MAX_PS = 10000000,
   localparam int LEN_W      = PAGE_BITS + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   output logic              req_ready,
   output logic              req_err,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_last,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_dq
);
   localparam int PAGE_WORDS = 1 << PAGE_BITS;
   localparam int ACC_CYC    = cdiv(T_ACC_PS, CLK_PS);
   localparam int PAGE_CYC   = cdiv(T_PAGE_PS, CLK_PS);
   localparam int FLOAT_CYC  = cdiv(T_FLOAT_PS, CLK_PS);
   localparam int PM_MAX_CYC = T_PM_MAX_PS / CLK_PS;
   localparam int RUN_CYC    = ACC_CYC + (PAGE_WORDS - 1) * PAGE_CYC;
   localparam int T_MAX      = imax3(ACC_CYC, PAGE_CYC, FLOAT_CYC);
   localparam int TW         = (T_MAX > 1) ? $clog2(T_MAX) : 1;
   localparam int BW         = $clog2(PM_MAX_CYC + 1);
   localparam int IW         = $clog2(FLOAT_CYC + 1);

   initial begin
      if (ADDR_W <= PAGE_BITS) $fatal(1, "address narrower than page field");
      if (CLK_PS <= 0)         $fatal(1, "clock period must be positive");
      // R7: a full-page run has to fit the page-mode window
      if (RUN_CYC > PM_MAX_CYC) $fatal(1, "full-page run exceeds page-mode limit");
   end

   pg_state_e         state_q;
   logic              bus_off_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  left_q;
   logic              err_q;

   logic              fits;
   logic              take, refuse;
   logic              t_load, t_done;
   logic [TW-1:0]     t_val;
   logic              cap_strobe;
   logic              final_word;

   psram_pg_reqchk #(.PAGE_BITS(PAGE_BITS), .LEN_W(LEN_W)) u_chk (
      .offset (req_addr[PAGE_BITS-1:0]),
      .len    (req_len),
      .fits   (fits)
   );

   assign req_ready  = (state_q == ST_IDLE);
   assign take       = req_valid && req_ready && fits;
   assign refuse     = req_valid && req_ready && !fits;
   assign final_word = (left_q == LEN_W'(1));
   assign cap_strobe = (state_q == ST_READ) && t_done;

   always_comb begin
      t_load = 1'b0;
      t_val  = '0;
      if (take) begin
         t_load = 1'b1;
         t_val  = TW'(ACC_CYC - 1);
      end else if (cap_strobe) begin
         t_load = 1'b1;
         t_val  = final_word ? TW'(FLOAT_CYC - 1) : TW'(PAGE_CYC - 1);
      end
   end

   psram_pg_timer #(.MAX_CYC(T_MAX)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .done     (t_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         bus_off_q <= 1'b1;
         addr_q    <= '0;
         left_q    <= '0;
         err_q     <= 1'b0;
      end else begin
         err_q <= refuse;
         case (state_q)
            ST_IDLE: begin
               if (take) begin
                  state_q   <= ST_READ;
                  bus_off_q <= 1'b0;
                  addr_q    <= req_addr;
                  left_q    <= req_len;
               end
            end
            ST_READ: begin
               if (t_done) begin
                  if (final_word) begin
                     state_q   <= ST_RECOVER;
                     bus_off_q <= 1'b1;
                  end else begin
                     addr_q[PAGE_BITS-1:0] <= addr_q[PAGE_BITS-1:0] + 1'b1;
                     left_q                <= left_q - 1'b1;
                  end
               end
            end
            ST_RECOVER: begin
               if (t_done) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   psram_pg_capture #(.DATA_W(DATA_W)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .strobe  (cap_strobe),
      .last_in (final_word),
      .dq      (mem_dq),
      .valid   (rd_valid),
      .data    (rd_data),
      .last    (rd_last)
   );

   assign mem_ce_n = bus_off_q;
   assign mem_oe_n = bus_off_q;
   assign mem_addr = addr_q;
   assign req_err  = err_q;

   // ---------------- checker state and assertions ----------------
   logic [BW-1:0] run_cyc_q;
   logic [IW-1:0] idle_cyc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cyc_q  <= '0;
         idle_cyc_q <= IW'(FLOAT_CYC);
      end else begin
         if (!mem_ce_n) begin
            if (run_cyc_q != BW'(PM_MAX_CYC)) run_cyc_q <= run_cyc_q + 1'b1;
         end else begin
            run_cyc_q <= '0;
         end
         if (!mem_ce_n)
            idle_cyc_q <= '0;
         else if (idle_cyc_q != IW'(FLOAT_CYC))
            idle_cyc_q <= idle_cyc_q + 1'b1;
      end
   end

   p_err_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_err |-> mem_ce_n && req_ready);
   p_enables_paired_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_ce_n |-> !mem_oe_n && !req_ready);
   p_upper_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |->
         mem_addr[ADDR_W-1:PAGE_BITS] == $past(mem_addr[ADDR_W-1:PAGE_BITS]));
   p_page_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n) && mem_addr != $past(mem_addr)) |->
         mem_addr[PAGE_BITS-1:0] == $past(mem_addr[PAGE_BITS-1:0]) + 1'b1);
   p_valid_in_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(!mem_ce_n));
   p_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_ce_n |-> run_cyc_q < BW'(PM_MAX_CYC));
   p_float_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_ce_n) |-> $past(idle_cyc_q) == IW'(FLOAT_CYC));
   p_busy_ignores_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && req_valid) |=> !req_err);
endmodule

// File: tb/tb_psram_page_reader.sv
`timescale 1ns/1ps
module tb_psram_page_reader;
   localparam int CLK_PS = 4000;
   localparam int ACC    = (75000 + CLK_PS - 1) / CLK_PS;
   localparam int PAGE   = (30000 + CLK_PS - 1) / CLK_PS;
   localparam int FLT    = (20000 + CLK_PS - 1) / CLK_PS;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [21:0] req_addr = '0;
   logic [3:0]  req_len = '0;
   logic        req_ready, req_err, rd_valid, rd_last;
   logic [15:0] rd_data;
   logic        mem_ce_n, mem_oe_n;
   logic [21:0] mem_addr;
   logic [15:0] mem_dq = 16'h0;

   int checks = 0;
   int fails  = 0;
   int seen_words = 0;
   int want_words = 0;

   always #2 clk = ~clk;

   psram_page_reader dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_len(req_len), .req_ready(req_ready), .req_err(req_err),
      .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last),
      .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
      .mem_dq(mem_dq)
   );

   function automatic logic [15:0] word_at(input logic [21:0] a);
      return a[15:0] ^ {a[21:16], a[21:12]} ^ 16'h5A3C;
   endfunction

   // memory model: true data only once the access time has elapsed
   logic [21:0] prev_addr = '0;
   logic        prev_ce_n = 1'b1;
   int          age = 0;
   bit          first_acc = 1'b1;
   always @(negedge clk) begin
      if (mem_ce_n) begin
         age = 0; first_acc = 1'b1;
      end else if (prev_ce_n) begin
         age = 1; first_acc = 1'b1;
      end else if (mem_addr != prev_addr) begin
         age = 1; first_acc = 1'b0;
      end else begin
         age = age + 1;
      end
      prev_addr = mem_addr;
      prev_ce_n = mem_ce_n;
      if (!mem_ce_n && !mem_oe_n && age * CLK_PS >= (first_acc ? 75000 : 30000))
         mem_dq <= word_at(mem_addr);
      else
         mem_dq <= 16'hBAD0 ^ 16'(age);
   end

   always @(negedge clk) if (rst_n && rd_valid) seen_words++;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   // refused request: R2
   task automatic bad_req(input logic [21:0] a, input logic [3:0] n);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_len = n;
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_err == 1'b1, "R2", "err pulse", 32'(req_err), 1);
      chk(mem_ce_n == 1'b1 && req_ready == 1'b1, "R2", "no bus activity",
          {30'd0, mem_ce_n, req_ready}, 3);
      @(negedge clk);
      chk(req_err == 1'b0, "R2", "err one cycle", 32'(req_err), 0);
   endtask

   // accepted run, optionally poking a request mid-run (R9)
   task automatic run(input logic [21:0] a, input logic [3:0] n, input bit poke);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_len = n;
      want_words += int'(n);
      @(negedge clk);                       // one cycle after accepting edge
      req_valid = 1'b0;
      chk(mem_ce_n == 1'b0 && mem_oe_n == 1'b0, "R3", "enables low",
          {30'd0, mem_ce_n, mem_oe_n}, 0);
      for (int k = 0; k < int'(n); k++) begin
         int w;
         w = (k == 0) ? ACC : PAGE;
         for (int c = 0; c < w - 1; c++) begin
            if (poke && k == 0 && c == 0) begin
               req_valid = 1'b1; req_addr = a ^ 22'h155; req_len = 4'd0;
            end
            @(negedge clk);
            if (poke && k == 0 && c == 0) begin
               req_valid = 1'b0;
               chk(req_err == 1'b0, "R9", "busy request ignored", 32'(req_err), 0);
            end
         end
         chk(rd_valid == 1'b0, (k == 0) ? "R4" : "R5", "no early valid",
             32'(rd_valid), 0);
         chk(mem_addr[21:3] == a[21:3], "R3", "upper address held",
             32'(mem_addr[21:3]), 32'(a[21:3]));
         @(negedge clk);
         chk(rd_valid == 1'b1, (k == 0) ? "R4" : "R5", "valid on time",
             32'(rd_valid), 1);
         chk(rd_data == word_at({a[21:3], a[2:0] + 3'(k)}), "R6", "data",
             32'(rd_data), 32'(word_at({a[21:3], a[2:0] + 3'(k)})));
         chk(rd_last == (k == int'(n) - 1), "R6", "last flag",
             32'(rd_last), 32'(k == int'(n) - 1));
      end
      chk(mem_ce_n == 1'b1 && mem_oe_n == 1'b1, "R8", "enables released",
          {30'd0, mem_ce_n, mem_oe_n}, 3);
      repeat (FLT - 1) @(negedge clk);
      chk(req_ready == 1'b0, "R8", "float gap busy", 32'(req_ready), 0);
      @(negedge clk);
      chk(req_ready == 1'b1, "R8", "ready after gap", 32'(req_ready), 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      int unsigned seed_init;
      seed_init = $urandom(32'h2C61);
      repeat (3) @(negedge clk);
      chk(mem_ce_n && mem_oe_n && !rd_valid && !req_err && req_ready, "R1",
          "reset state", {27'd0, mem_ce_n, mem_oe_n, rd_valid, req_err, req_ready}, 32'h19);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 1);

      // directed corners
      run(22'h000000, 4'd8, 1'b0);        // R10 full page
      run(22'h12345F, 4'd1, 1'b0);        // R10 offset 7, one word
      run(22'h3FFFF8, 4'd8, 1'b1);        // top page, poke mid-run (R9)
      run(22'h0ABC03, 4'd5, 1'b0);        // ends exactly on boundary (R10)
      bad_req(22'h00000F, 4'd2);          // offset 7 length 2 crosses
      bad_req(22'h000010, 4'd0);          // zero length
      bad_req(22'h000020, 4'd9);          // longer than a page

      // constrained random
      for (int i = 0; i < 150; i++) begin
         logic [21:0] a;
         int off, n;
         a   = 22'($urandom());
         off = int'(a[2:0]);
         if ($urandom_range(0, 5) == 0) begin
            n = ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(9 - off, 15);
            bad_req(a, 4'(n));
         end else begin
            n = $urandom_range(1, 8 - off);
            run(a, 4'(n), $urandom_range(0, 3) == 0);
         end
      end

      repeat (4) @(negedge clk);
      chk(seen_words == want_words, "R6", "total valid pulses",
          32'(seen_words), 32'(want_words));
      summary();
   end
endmodule